// File: doc/BRIEF.md
# Pointer Tag Generation Unit

This unit computes tagged 64-bit pointer values for two operations used when memory is protected by small lock-and-key tags. A pointer carries a 4-bit key in its top byte, at bits 59:56. The unit either gives a fresh pointer a pseudo-random key, or derives a neighbouring pointer from a base one. Storing the keys to memory and comparing them on loads and stores belong to other blocks.

The random-key operation copies the source word and replaces only the key field. The key comes from a 16-bit maximal-length shift register, and a caller-supplied mask can rule out some key values. The offset operation moves the address part forward by a whole number of 16-byte granules and adds a small amount to the key. The address and the key are updated as two independent fields, so no carry passes from one to the other. A request is taken in any cycle in which `req_valid` is high, and its result appears, registered, in the next cycle.

Top module: `ptag_gen_unit`

## Requirements
- R1: While reset is held, and after it until the first request, `res_valid` is 0 and `res_data` is all zeros.
- R2: `res_valid` is 1 in exactly the cycle after each cycle with `req_valid` high, and `req_ready` is 1 in every cycle.
- R3: For the random-key operation (`req_op` = 0), bits 63:60 and 55:0 of the result equal the same bits of `req_src`.
- R4: The shift register resets to 16'hACE1. It shifts left with the new bit 0 = s[15]^s[13]^s[12]^s[10]. It advances exactly once for each accepted random-key request and never for an offset request. The candidate key is its bits 3:0 before the advance.
- R5: With a random-key request, the result key is never a value whose bit is set in `req_excl` (bit k bars key k), unless all 16 bits are set.
- R6: When the candidate key is barred, the key used is the first unbarred value that follows it in increasing order, wrapping from 15 to 0.
- R7: When `req_excl` is 16'hFFFF, the random-key result key is 0.
- R8: For the offset operation (`req_op` = 1), bits 55:0 of the result are (src[55:0] + 16*`req_imm_a`) mod 2^56, and a carry out of bit 55 is dropped.
- R9: For the offset operation, the result key is (src[59:56] + `req_imm_b`) mod 16, and bits 63:60 equal the source.
- R10: In a cycle after one without a request, `res_valid` is 0 and `res_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Unit can take a request (always 1) |
| req_op | input | 1 | 0 = random key insert, 1 = offset with key adjust |
| req_src | input | 64 | Source pointer |
| req_imm_a | input | 6 | Address offset in 16-byte granules |
| req_imm_b | input | 4 | Amount added to the key, mod 16 |
| req_excl | input | 16 | Barred key values for the random-key operation |
| res_valid | output | 1 | Result valid |
| res_data | output | 64 | Result pointer |

## Verification
The bench goes after the wrap corners. One is an address near 2^56 plus an offset, where a carry that leaked into the key would corrupt it. Another is a key of 15 plus an adjustment, where a wrong design would disturb bit 60. A third is a barred candidate of 15, where a design that searches without wrapping would return a barred or wrong key. It also mixes offset requests between random-key requests, so that a generator advancing on every request shows up as a wrong key sequence. It tests the fully barred mask, where a careless search would leave the candidate key in place. Requests go back to back and with gaps, which shows whether a result turns valid late or a held result changes.

// File: rtl/ptag_pkg.sv
package ptag_pkg;

   typedef enum logic {
      OP_RAND_KEY   = 1'b0,
      OP_OFFSET_KEY = 1'b1
   } ptag_op_e;

   localparam int unsigned PTR_W    = 64;
   localparam int unsigned KEY_W    = 4;
   localparam int unsigned KEY_LSB  = 56;
   localparam int unsigned IMMA_W   = 6;
   localparam int unsigned GRAN_LG2 = 4;
   localparam int unsigned LFSR_W   = 16;
   localparam logic [15:0] LFSR_SEED = 16'hACE1;
   localparam logic [15:0] LFSR_TAPS = 16'hB400;

endpackage

// File: rtl/ptag_lfsr.sv
module ptag_lfsr #(
   parameter int unsigned  W    = 16,
   parameter logic [W-1:0] SEED = 16'hACE1,
   parameter logic [W-1:0] TAPS = 16'hB400
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] state
);

   if (W < 2) begin : g_bad_w
      $error("ptag_lfsr: W must be at least 2");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("ptag_lfsr: SEED must be non-zero");
   end

   logic [W-1:0] st_q;
   logic         fb;

   assign fb = ^(st_q & TAPS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= SEED;
      end else if (step) begin
         st_q <= {st_q[W-2:0], fb};
      end
   end

   assign state = st_q;

endmodule

// File: rtl/ptag_key_pick.sv
module ptag_key_pick #(
   parameter int unsigned KW      = 4,
   parameter bit          EXCL_EN = 1'b1,
   localparam int unsigned NK     = 1 << KW
) (
   input  logic [KW-1:0] cand,
   input  logic [NK-1:0] barred,
   output logic [KW-1:0] key
);

   if (EXCL_EN) begin : g_search
      logic [KW-1:0] pick;
      logic          found;
      always_comb begin
         pick  = '0;
         found = 1'b0;
         for (int k = 0; k < int'(NK); k++) begin
            logic [KW-1:0] idx;
            idx = KW'(int'(cand) + k);
            if (!found && !barred[idx]) begin
               pick  = idx;
               found = 1'b1;
            end
         end
      end
      assign key = pick;
   end else begin : g_pass
      logic unused_barred;
      assign unused_barred = ^barred;
      assign key = cand;
   end

endmodule

// File: rtl/ptag_addr_step.sv
module ptag_addr_step #(
   parameter int unsigned AW       = 56,
   parameter int unsigned IW       = 6,
   parameter int unsigned GRAN_LG2 = 4,
   localparam int unsigned OFF_W   = IW + GRAN_LG2
) (
   input  logic [AW-1:0] addr,
   input  logic [IW-1:0] granules,
   output logic [AW-1:0] sum
);

   if (OFF_W > AW) begin : g_bad_off
      $error("ptag_addr_step: offset wider than address");
   end

   logic [OFF_W-1:0] off;
   assign off = {granules, {GRAN_LG2{1'b0}}};
   assign sum = addr + AW'(off);

endmodule

// File: rtl/ptag_gen_unit.sv
module ptag_gen_unit #(
   parameter int unsigned PTR_W     = ptag_pkg::PTR_W,
   parameter int unsigned KEY_W     = ptag_pkg::KEY_W,
   parameter int unsigned KEY_LSB   = ptag_pkg::KEY_LSB,
   parameter int unsigned IMMA_W    = ptag_pkg::IMMA_W,
   parameter int unsigned GRAN_LG2  = ptag_pkg::GRAN_LG2,
   parameter int unsigned LFSR_W    = ptag_pkg::LFSR_W,
   parameter logic [LFSR_W-1:0] LFSR_SEED = ptag_pkg::LFSR_SEED,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = ptag_pkg::LFSR_TAPS,
   parameter bit          EXCL_EN   = 1'b1,
   localparam int unsigned NKEYS    = 1 << KEY_W,
   localparam int unsigned KEY_MSB  = KEY_LSB + KEY_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_op,
   input  logic [PTR_W-1:0]  req_src,
   input  logic [IMMA_W-1:0] req_imm_a,
   input  logic [KEY_W-1:0]  req_imm_b,
   input  logic [NKEYS-1:0]  req_excl,
   output logic              res_valid,
   output logic [PTR_W-1:0]  res_data
);
   import ptag_pkg::*;

   if (KEY_MSB >= PTR_W - 1) begin : g_bad_key_pos
      $error("ptag_gen_unit: key field must sit below the top bit");
   end
   if (LFSR_W < KEY_W) begin : g_bad_lfsr
      $error("ptag_gen_unit: generator narrower than key");
   end

   ptag_op_e          op;
   logic              accept;
   logic [LFSR_W-1:0] rng;
   logic [KEY_W-1:0]  rand_key;
   logic [KEY_W-1:0]  src_key;
   logic [KEY_W-1:0]  adj_key;
   logic [KEY_LSB-1:0] addr_sum;
   logic [PTR_W-1:0]  rand_res;
   logic [PTR_W-1:0]  off_res;
   logic [PTR_W-1:0]  res_q;
   logic              vld_q;

   assign op        = ptag_op_e'(req_op);
   assign req_ready = 1'b1;
   assign accept    = req_valid && req_ready;

   ptag_lfsr #(
      .W    (LFSR_W),
      .SEED (LFSR_SEED),
      .TAPS (LFSR_TAPS)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (accept && (op == OP_RAND_KEY)),
      .state (rng)
   );

   ptag_key_pick #(
      .KW      (KEY_W),
      .EXCL_EN (EXCL_EN)
   ) u_pick (
      .cand   (rng[KEY_W-1:0]),
      .barred (req_excl),
      .key    (rand_key)
   );

   ptag_addr_step #(
      .AW       (KEY_LSB),
      .IW       (IMMA_W),
      .GRAN_LG2 (GRAN_LG2)
   ) u_addr (
      .addr     (req_src[KEY_LSB-1:0]),
      .granules (req_imm_a),
      .sum      (addr_sum)
   );

   assign src_key = req_src[KEY_MSB:KEY_LSB];
   assign adj_key = src_key + req_imm_b;

   always_comb begin
      rand_res                  = req_src;
      rand_res[KEY_MSB:KEY_LSB] = rand_key;
      off_res                   = req_src;
      off_res[KEY_LSB-1:0]      = addr_sum;
      off_res[KEY_MSB:KEY_LSB]  = adj_key;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         res_q <= '0;
      end else begin
         vld_q <= accept;
         if (accept) begin
            res_q <= (op == OP_RAND_KEY) ? rand_res : off_res;
         end
      end
   end

   assign res_valid = vld_q;
   assign res_data  = res_q;

endmodule

// File: rtl/ptag_gen_chk.sv
module ptag_gen_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_op,
   input logic [63:0] req_src,
   input logic [5:0]  req_imm_a,
   input logic [3:0]  req_imm_b,
   input logic [15:0] req_excl,
   input logic        res_valid,
   input logic [63:0] res_data
);

   // R2: a request yields a valid result one cycle later
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   // R2 / R10: no request, no valid result
   a_r10_idle_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);

   // R10: an idle cycle leaves the result unchanged
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(res_data));

   // R3: random-key keeps every non-key bit
   a_r3_keep_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(req_op) == 1'b0) |->
      (res_data[63:60] == $past(req_src[63:60]) &&
       res_data[55:0]  == $past(req_src[55:0])));

   // R5: a barred key is never produced unless all are barred
   a_r5_not_barred: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(req_op) == 1'b0 && $past(req_excl) != 16'hFFFF) |->
      ((($past(req_excl) >> res_data[59:56]) & 16'h0001) == 16'h0000));

   // R7: fully barred mask gives key 0
   a_r7_all_barred: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(req_op) == 1'b0 && $past(req_excl) == 16'hFFFF) |->
      (res_data[59:56] == 4'h0));

   // R8: address part moves by whole granules, wrapping in 56 bits
   a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(req_op) == 1'b1) |->
      (res_data[55:0] == 56'($past(req_src[55:0]) + {$past(req_imm_a), 4'h0})));

   // R9: key adjusted mod 16, top nibble untouched
   a_r9_key_adjust: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(req_op) == 1'b1) |->
      (res_data[59:56] == 4'($past(req_src[59:56]) + $past(req_imm_b)) &&
       res_data[63:60] == $past(req_src[63:60])));

endmodule

bind ptag_gen_unit ptag_gen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_op    (req_op),
   .req_src   (req_src),
   .req_imm_a (req_imm_a),
   .req_imm_b (req_imm_b),
   .req_excl  (req_excl),
   .res_valid (res_valid),
   .res_data  (res_data)
);

// File: tb/ptag_gen_unit_test.sv
`timescale 1ns/1ps
module ptag_gen_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_op = 1'b0;
   logic [63:0] req_src = '0;
   logic [5:0]  req_imm_a = '0;
   logic [3:0]  req_imm_b = '0;
   logic [15:0] req_excl = '0;
   logic        res_valid;
   logic [63:0] res_data;

   int checks = 0;
   int errors = 0;

   logic [63:0] exp_q[$];
   string       req_q[$];
   logic [15:0] m_lfsr = 16'hACE1;
   logic [63:0] last_res = '0;

   always #5 clk = ~clk;

   ptag_gen_unit uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_op    (req_op),
      .req_src   (req_src),
      .req_imm_a (req_imm_a),
      .req_imm_b (req_imm_b),
      .req_excl  (req_excl),
      .res_valid (res_valid),
      .res_data  (res_data)
   );

   task automatic check64(input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // R6 model: walk upward from the candidate, wrapping, to the first free key
   function automatic logic [3:0] model_key(input logic [3:0] cand, input logic [15:0] ex);
      logic [3:0] t;
      t = cand;
      if (ex == 16'hFFFF) return 4'h0;   // R7
      while (ex[t]) t = t + 4'd1;
      return t;
   endfunction

   // R4 model: generator step
   function automatic logic [15:0] model_step(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   // driver: drive one request for one cycle and push its expected result
   task automatic issue(input logic op, input logic [63:0] src, input logic [5:0] a,
                        input logic [3:0] b, input logic [15:0] ex, input string rq);
      logic [63:0] e;
      e = src;
      if (op == 1'b0) begin
         e[59:56] = model_key(m_lfsr[3:0], ex);
         m_lfsr   = model_step(m_lfsr);
      end else begin
         e[55:0]  = src[55:0] + {46'd0, a, 4'd0};
         e[59:56] = src[59:56] + b;
      end
      exp_q.push_back(e);
      req_q.push_back(rq);
      req_valid = 1'b1;
      req_op    = op;
      req_src   = src;
      req_imm_a = a;
      req_imm_b = b;
      req_excl  = ex;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      req_valid = 1'b0;
      req_src   = 64'hDEAD_BEEF_0BAD_F00D;
      repeat (n) @(negedge clk);
   endtask

   // monitor: pop and compare each valid result
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R2 actual=unexpected valid expected=no result");
         end else begin
            logic [63:0] e;
            string       rq;
            e  = exp_q.pop_front();
            rq = req_q.pop_front();
            check64(rq, res_data, e);
         end
         last_res = res_data;
      end
   end

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check64("R1 valid in reset", {63'd0, res_valid}, 64'd0);
      check64("R1 data in reset", res_data, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check64("R1 valid after reset", {63'd0, res_valid}, 64'd0);
      check64("R2 ready", {63'd0, req_ready}, 64'd1);

      // R3 R4: first key from seed, other bits intact
      issue(1'b0, 64'h0123_4567_89AB_CDEF, 6'd0, 4'd0, 16'h0000, "R3 R4 first key");
      // R8: address wraps, carry must not reach key
      issue(1'b1, 64'h00FF_FFFF_FFFF_FFF0, 6'd1, 4'd3, 16'h0000, "R8 addr wrap");
      // R9: key wrap 15+2
      issue(1'b1, 64'hAF00_0000_0000_1230, 6'd63, 4'd2, 16'h0000, "R9 key wrap");
      // R4: offset ops do not advance generator
      issue(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 4'd0, 16'h0000, "R4 no advance on offset");
      // R7: all barred
      issue(1'b0, 64'h5555_5555_5555_5555, 6'd0, 4'd0, 16'hFFFF, "R7 all barred");
      // R5 R6: only key 0 free / only key 15 free
      issue(1'b0, 64'h1234_0000_0000_0000, 6'd0, 4'd0, 16'hFFFE, "R6 only zero free");
      issue(1'b0, 64'h1234_0000_0000_0000, 6'd0, 4'd0, 16'h7FFF, "R6 only fifteen free");
      issue(1'b0, 64'h0000_0000_0000_0040, 6'd0, 4'd0, 16'h8001, "R5 R6 wrap search");
      idle(1);
      // R10: idle cycle holds result
      check64("R10 valid low when idle", {63'd0, res_valid}, 64'd0);
      check64("R10 data held", res_data, last_res);
      idle(2);

      for (int i = 0; i < 400; i++) begin
         logic        op;
         logic [15:0] ex;
         int          sel;
         op  = 1'($urandom_range(0, 1));
         sel = $urandom_range(0, 7);
         ex  = (sel == 0) ? 16'hFFFF : (sel < 3) ? 16'h0000 : 16'($urandom);
         issue(op, {$urandom, $urandom}, 6'($urandom), 4'($urandom), ex,
               op ? "R8 R9 random offset" : "R4 R5 R6 random key");
         if ((i % 37) == 0) idle(1);
      end
      idle(3);
      check64("R2 all results seen", 64'(exp_q.size()), 64'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule